// File: doc/BRIEF.md
# Grouped External Interrupt Controller

The block watches 28 external interrupt lines, numbered 0 to 27. Each line first passes through a two-flop synchroniser. A detector then checks the line against a programmable trigger condition: low level, high level, falling edge, rising edge or either edge. A detected trigger sets the line's pending bit. Pending bits that are not masked are ORed into four grouped request outputs for a parent interrupt controller. The groups are uneven: 4, 8, 8 and 8 lines.

Software reaches the block through a small synchronous register port with four word addresses. Two configuration words hold the trigger fields, and one trigger field is shared by each pair of adjacent lines. The other two words are a mask and a write-one-to-clear pending word. A handler reads the pending and mask words to find which lines in its group need service. It clears a pending bit once that line's cause is gone.

Top module: `xint_group_ctrl`

## Requirements
- R1: The register port decodes a 2-bit word address: 0 is the configuration word for lines 0..15, 1 is the configuration word for lines 16..27, 2 is the mask and 3 is the pending word. A write takes effect at the clock edge where write enable is high. Read data is combinational from the address in the same cycle.
- R2: Lines 2k and 2k+1 share one 3-bit trigger field. For line n, let m be n within configuration word 0 and n-16 within word 1. The field occupies bits (m/2)*4+2 down to (m/2)*4. Bit 3 of every nibble reads 0.
- R3: The trigger codes are 000 low level, 001 high level, 010 falling edge, 100 rising edge and 110 either edge. Codes 011, 101 and 111 never set the pending bit.
- R4: An input change applied before clock edge k can set the pending bit at edge k+2 at the earliest. Edges are found by comparing the synchronised value with its value one cycle earlier.
- R5: A mask bit of 1 keeps its line out of the group outputs, and a mask bit of 0 lets it through. Masking never changes the pending bits.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. A pending bit otherwise holds its value.
- R7: If a trigger and a clear of the same bit occur in one cycle, the pending bit stays set. As a result, a level trigger whose level is still active keeps its bit set.
- R8: Group output 0 is the OR of pending and unmasked lines 0..3. Output 1 covers lines 4..11, output 2 covers lines 12..19 and output 3 covers lines 20..27.
- R9: Write data for lines above 27 has no effect. This covers mask and pending bits 31..28 and configuration word 1 bits 31..24, and all of them read as 0.
- R10: While reset is asserted, all mask bits read 1, all pending bits read 0, all trigger fields read 0 and all group outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_i | input | 28 | Asynchronous external interrupt lines |
| we_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational |
| grp_o | output | 4 | Grouped interrupt requests to the parent controller |

## Verification
The bench goes after several corner cases, and each has a distinct failure signature:
- A clear that lands while a level is still active must leave the bit set. A design that lets the clear win would drop a live request.
- Each line of a shared-field pair must follow the same trigger. A design that decoded one field per line would ignore the second line of a pair.
- Configuration bits for the non-existent lines 28 to 31 must read back as zero. A design that stored them would show stray ones.
- An edge on an input must appear exactly two edges later, counted from the sample edge. An off-by-one synchroniser would set the pending bit one cycle early or late.
- An undefined trigger code must never set a bit.
- The groups must split at lines 4, 12 and 20. A slip at a group boundary would raise the wrong parent output.

Long random traffic on inputs and registers is compared cycle by cycle against a reference model kept in the bench.

// File: rtl/xint_pkg.sv
package xint_pkg;
  localparam int unsigned XI_LINES  = 28;
  localparam int unsigned XI_GROUPS = 4;
  localparam int unsigned XI_DW     = 32;
  localparam int unsigned XI_NIB    = 4;

  typedef enum logic [1:0] {
    ADDR_CFG0 = 2'd0,
    ADDR_CFG1 = 2'd1,
    ADDR_MASK = 2'd2,
    ADDR_PEND = 2'd3
  } xi_addr_e;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'b000,
    TRIG_HIGH = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_RISE = 3'b100,
    TRIG_BOTH = 3'b110
  } xi_trig_e;

  // uneven grouping: 4, 8, 8, 8 lines
  function automatic int unsigned xi_group(int unsigned n);
    if (n < 4)       return 0;
    else if (n < 12) return 1;
    else if (n < 20) return 2;
    else             return 3;
  endfunction
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/xint_line.sv
module xint_line import xint_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [2:0] code_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic prev_q, pend_q, hit;

  always_comb begin
    case (xi_trig_e'(code_i))
      TRIG_LOW:  hit = ~lvl_i;
      TRIG_HIGH: hit = lvl_i;
      TRIG_FALL: hit = prev_q & ~lvl_i;
      TRIG_RISE: hit = ~prev_q & lvl_i;
      TRIG_BOTH: hit = prev_q ^ lvl_i;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= (pend_q & ~clr_i) | hit;  // set beats clear
    end
  end

  assign pend_o = pend_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && clr_i |=> pend_o);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !hit |=> !pend_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !clr_i |=> pend_o);
endmodule

// File: rtl/xint_group_ctrl.sv
module xint_group_ctrl import xint_pkg::*; #(
  parameter int unsigned NL = XI_LINES,
  parameter int unsigned DW = XI_DW,
  parameter int unsigned NG = XI_GROUPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NL-1:0] ext_i,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NG-1:0] grp_o
);
  localparam int unsigned NPAIR = (NL + 1) / 2;
  localparam int unsigned PPR   = DW / XI_NIB;  // pairs per config word

  logic [2:0]    cfg_q [NPAIR];
  logic [NL-1:0] mask_q, pend, clr, lvl, act;
  wire           unused_wd = ^wdata_i;

  xint_sync #(.W(NL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_i),
    .q_o   (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      for (int p = 0; p < int'(NPAIR); p++) cfg_q[p] <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_MASK) mask_q <= wdata_i[NL-1:0];
      for (int p = 0; p < int'(NPAIR); p++)
        if (addr_i == 2'(p / int'(PPR)))
          cfg_q[p] <= wdata_i[(p % int'(PPR))*XI_NIB +: 3];
    end
  end

  assign clr = (we_i && addr_i == ADDR_PEND) ? wdata_i[NL-1:0] : '0;

  for (genvar i = 0; i < int'(NL); i++) begin : g_line
    xint_line u_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl[i]),
      .code_i(cfg_q[i/2]),
      .clr_i (clr[i]),
      .pend_o(pend[i])
    );
  end

  assign act = pend & ~mask_q;

  for (genvar g = 0; g < int'(NG); g++) begin : g_grp
    logic [NL-1:0] sel;
    always_comb
      for (int unsigned n = 0; n < NL; n++) sel[n] = (xi_group(n) == g);
    assign grp_o[g] = |(act & sel);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_MASK)      rdata_o[NL-1:0] = mask_q;
    else if (addr_i == ADDR_PEND) rdata_o[NL-1:0] = pend;
    else
      for (int p = 0; p < int'(NPAIR); p++)
        if (addr_i == 2'(p / int'(PPR)))
          rdata_o[(p % int'(PPR))*XI_NIB +: 3] = cfg_q[p];
  end

  a_r5_mask_all_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == ADDR_MASK && (&wdata_i[NL-1:0]) |=> grp_o == '0);
  a_r9_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_MASK || addr_i == ADDR_PEND) |-> (rdata_o >> NL) == '0);
  a_r2_spare_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_CFG0 || addr_i == ADDR_CFG1) |-> (rdata_o & 32'h8888_8888) == '0);
  a_r10_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> grp_o == '0);
endmodule

// File: tb/sim_xint_group_ctrl.sv
`timescale 1ns/1ps
module sim_xint_group_ctrl;
  logic        clk = 0, rst_ni = 0, we = 0;
  logic [27:0] ext = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0]  grp;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  xint_group_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_i(ext), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .grp_o(grp)
  );

  // reference model
  logic [27:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_pend = '0, m_mask = '1;
  logic [2:0]  m_cfg [14];

  function automatic logic trig(logic [2:0] c, logic s, logic p);
    case (c)
      3'b000:  return ~s;
      3'b001:  return s;
      3'b010:  return p & ~s;
      3'b100:  return ~p & s;
      3'b110:  return p ^ s;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    logic [31:0] r = '0;
    if (a == 2) r[27:0] = m_mask;
    else if (a == 3) r[27:0] = m_pend;
    else for (int p = 0; p < 14; p++) if (p / 8 == int'(a)) r[(p % 8)*4 +: 3] = m_cfg[p];
    return r;
  endfunction

  function automatic logic [3:0] exp_grp();
    logic [27:0] a = m_pend & ~m_mask;
    return {|a[27:20], |a[19:12], |a[11:4], |a[3:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [27:0] x, logic w, logic [1:0] a, logic [31:0] d);
    logic [27:0] hit, clr;
    ext = x; we = w; addr = a; wdata = d;
    @(posedge clk);
    for (int n = 0; n < 28; n++) hit[n] = trig(m_cfg[n/2], m_s2[n], m_prev[n]);
    clr = (w && a == 3) ? d[27:0] : '0;
    m_pend = (m_pend & ~clr) | hit;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = x;
    if (w && a == 2) m_mask = d[27:0];
    if (w && a < 2)
      for (int p = 0; p < 14; p++) if (p / 8 == int'(a)) m_cfg[p] = d[(p % 8)*4 +: 3];
    @(negedge clk);
    we = 0;
    case (a)
      2'd0, 2'd1: chk("R1/R2 cfg read", rdata, exp_rd(a));
      2'd2:       chk("R5 mask read", rdata, exp_rd(a));
      default:    chk("R6/R7 pending read", rdata, exp_rd(a));
    endcase
    chk("R8 group outputs", {28'd0, grp}, {28'd0, exp_grp()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [27:0] x;
    void'($urandom(32'd20240611));
    for (int p = 0; p < 14; p++) m_cfg[p] = '0;
    repeat (3) @(posedge clk);
    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #0.2;
      chk("R10 reset read", rdata, a == 2 ? 32'h0FFF_FFFF : 32'h0);
    end
    chk("R10 reset groups", {28'd0, grp}, 32'h0);
    @(negedge clk); rst_ni = 1;

    // R9 absent lines in cfg1 and mask
    cyc('0, 1, 1, 32'hFFFF_FFFF);
    chk("R9 cfg1 upper", rdata, 32'h0077_7777);
    cyc('0, 1, 2, 32'hFFFF_FFFF);
    chk("R9 mask upper", rdata, 32'h0FFF_FFFF);
    cyc('0, 1, 1, 32'h0);

    // R4 latency on rising line 5
    cyc('0, 1, 0, 32'h0000_0400);
    cyc('0, 1, 2, 32'h0FFF_FFDF);
    cyc('0, 1, 3, 32'h0000_0020);
    cyc('0, 0, 3, 0);
    chk("R6 cleared bit 5", rdata & 32'h20, 32'h0);
    x = 28'h20;
    cyc(x, 0, 3, 0); chk("R4 edge k", rdata & 32'h20, 32'h0);
    cyc(x, 0, 3, 0); chk("R4 edge k+1", rdata & 32'h20, 32'h0);
    cyc(x, 0, 3, 0); chk("R4 edge k+2", rdata & 32'h20, 32'h20);
    chk("R8 line 5 in group 1", {28'd0, grp}, 32'h2);
    cyc(x, 1, 2, 32'h0FFF_FFFF);
    chk("R5 masked groups", {28'd0, grp}, 32'h0);
    cyc(x, 0, 3, 0);
    chk("R5 pending kept", rdata & 32'h20, 32'h20);
    cyc(x, 1, 3, 32'h0);
    chk("R6 write zero", rdata & 32'h20, 32'h20);
    cyc(x, 1, 3, 32'h20);
    chk("R6 write one", rdata & 32'h20, 32'h0);

    // R7 high level on line 20
    cyc(x, 1, 1, 32'h0000_0100);
    x = x | 28'h010_0000;
    repeat (3) cyc(x, 0, 3, 0);
    chk("R7 level set", rdata & 32'h0010_0000, 32'h0010_0000);
    cyc(x, 1, 3, 32'h0010_0000);
    chk("R7 set wins over clear", rdata & 32'h0010_0000, 32'h0010_0000);
    x = 28'h20;
    repeat (3) cyc(x, 0, 3, 0);
    cyc(x, 1, 3, 32'h0010_0000);
    chk("R7 clear after level drops", rdata & 32'h0010_0000, 32'h0);

    // R3 invalid code; R2 shared field for lines 6 and 7
    cyc(x, 1, 0, 32'h0000_2403);
    x = x | 28'hC0;
    repeat (3) cyc(x, 0, 3, 0);
    cyc(x, 1, 3, 32'h0000_00C3);
    repeat (3) cyc(x, 0, 3, 0);
    chk("R3 invalid code idle", rdata & 32'h3, 32'h0);
    chk("R2 pair idle", rdata & 32'hC0, 32'h0);
    x = 28'h20;
    repeat (3) cyc(x, 0, 3, 0);
    chk("R2 pair both fall", rdata & 32'hC0, 32'hC0);
    chk("R3 invalid code held", rdata & 32'h3, 32'h0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [1:0]  a;
      logic [31:0] d;
      if ($urandom % 4 == 0) x = x ^ (28'd1 << ($urandom % 28));
      w = ($urandom % 4 == 0);
      a = 2'($urandom % 4);
      d = $urandom;
      cyc(x, w, a, d);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule